// File: doc/BRIEF.md
# Calibrated Two-Stage Seconds Prescaler

This block turns a free-running real-time-clock input into a once-per-second calendar enable. A first divider counts input cycles and emits a pulse every `async_reload + 1` counted cycles. A second divider counts those pulses and emits the seconds tick every `sync_reload + 1` of them. The second divider's down-counter is exposed as the subsecond value. With a 32.768 kHz input and the reset reload values 127 and 255, the subsecond value steps in units of 1/256 s.

Frequency trimming is done digitally across a long calibration window, not by changing the dividers. The window is 2^20 input cycles by default (32 s at 32.768 kHz), or a half or quarter of that. It holds 512 evenly spaced slots. At the first cycle of a slot, a calibration sequencer can withhold that cycle's count (the cycle is masked). At the middle cycle of a slot, it can count that cycle twice (an extra pulse is inserted). Over a full window the net gain in counted cycles is `512*cal_plus - cal_mask`. One step is about 0.954 ppm, which gives a range of roughly -487 ppm to +488 ppm.

The sequencer is a three-state machine whose state sets how much the current input cycle counts:
- RUN counts the cycle once.
- SKIP counts it zero times.
- EXTRA counts it twice.

The next state is chosen each cycle from the value the window counter will hold next. The transitions are:
- any state to SKIP when that value opens a masked slot;
- any state to EXTRA when that value is a slot midpoint and insertion is enabled;
- any state to RUN otherwise.

Reset enters RUN with the window counter at its last value, so the first counted cycle after reset is an ordinary one.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst_n` is low, `subsec` equals DEF_SYNC (255) and `apre_tick` and `tick_1hz` are 0. After reset the first-stage count starts at DEF_ASYNC (127), so the first `apre_tick` follows the 128th counted cycle.
- R2: After the first pulse, `apre_tick` is a one-cycle pulse issued each time the running total of counted input cycles passes another `async_reload + 1`. Each RUN cycle counts 1, each SKIP cycle counts 0 and each EXTRA cycle counts 2.
- R3: Each `apre_tick` decrements `subsec`. If `subsec` is 0 when an `apre_tick` arrives, `subsec` reloads with `sync_reload` and `tick_1hz` pulses in that same cycle.
- R4: With `cal_win` = 00, the window is 2^WIN_LOG2 cycles split into 512 slots of 2^(WIN_LOG2-9) cycles. The slot index is the top 9 bits of the window count. The first cycle of a slot is masked when the bit-reversed slot index is below `cal_mask`, so exactly `cal_mask` cycles are masked per window.
- R5: Masking is spread evenly: with `cal_mask` = 256, every even-numbered slot is masked and every odd one is not. The first half of the window therefore loses 128 cycles.
- R6: `cal_win` = 01 selects a half window. The top slot-index bit and `cal_mask` bit 0 are ignored, so `2*(cal_mask>>1)` cycles are masked per full-length span. `cal_win` = 10 or 11 selects a quarter window, ignoring the top two index bits and `cal_mask` bits 1:0, so `4*(cal_mask>>2)` cycles are masked per full-length span.
- R7: With `cal_plus` = 1, the middle cycle of every slot (offset 2^(WIN_LOG2-10)) counts twice. This gives 512 inserted counts per 2^WIN_LOG2 cycles and a net gain of `512*cal_plus - cal_mask`.
- R8: Insertion is suppressed while `async_reload` is below 3, even with `cal_plus` = 1.
- R9: `apre_tick` and `tick_1hz` come from registers, and `tick_1hz` is never high in a cycle where `apre_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time-clock input; every rising edge is one input cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_reload | input | ASYNC_W (7) | First-stage divide value minus one |
| sync_reload | input | SYNC_W (15) | Second-stage divide value minus one |
| cal_plus | input | 1 | Enables one inserted count per slot |
| cal_mask | input | 9 | Number of masked cycles per full window |
| cal_win | input | 2 | Window length: 00 full, 01 half, 1x quarter |
| apre_tick | output | 1 | One-cycle first-stage pulse |
| tick_1hz | output | 1 | One-cycle seconds pulse |
| subsec | output | SYNC_W (15) | Second-stage down-counter (subsecond value) |

## Verification
The assertions assume the four configuration inputs change only while `rst_n` is low. In particular, the check that EXTRA occurs only when insertion is allowed, and the check that `subsec` equals `sync_reload` after a seconds tick, both compare registered state against the live configuration. The bench therefore drives every configuration, directed or drawn from `$urandom`, before it releases reset and holds it fixed until the next reset. Reload values below 3 are drawn on purpose so that the insertion gate is exercised from both sides.

// File: rtl/rtcpre_pkg.sv
package rtcpre_pkg;

    localparam int MASK_W = 9;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SKIP  = 2'd1,
        ST_EXTRA = 2'd2
    } slot_state_e;

    function automatic logic [MASK_W-1:0] rev_bits(input logic [MASK_W-1:0] v);
        logic [MASK_W-1:0] r;
        for (int i = 0; i < MASK_W; i++) begin
            r[i] = v[MASK_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rtcpre_cal_seq.sv
module rtcpre_cal_seq
    import rtcpre_pkg::*;
#(
    parameter int WIN_LOG2 = 20,
    parameter int ASYNC_W  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cal_plus,
    input  logic [MASK_W-1:0]      cal_mask,
    input  logic [1:0]             cal_win,
    input  logic [ASYNC_W-1:0]     async_reload,
    output logic [1:0]             credit
);
    localparam int SLOT_LOG2 = WIN_LOG2 - MASK_W;
    localparam logic [SLOT_LOG2-1:0] SLOT_MID = {1'b1, {(SLOT_LOG2-1){1'b0}}};

    slot_state_e           state_q, state_nx;
    logic [WIN_LOG2-1:0]   wc_q, wc_nx;
    logic [MASK_W-1:0]     idx, idx_m, calm_m;
    logic                  insert_ok;

    // next-state decision, taken from the window count one cycle ahead
    always_comb begin
        wc_nx     = wc_q + 1'b1;
        idx       = wc_nx[WIN_LOG2-1 -: MASK_W];
        insert_ok = cal_plus && (async_reload >= ASYNC_W'(3));
        if (cal_win[1]) begin
            idx_m  = idx & 9'h07F;
            calm_m = cal_mask & 9'h1FC;
        end else if (cal_win[0]) begin
            idx_m  = idx & 9'h0FF;
            calm_m = cal_mask & 9'h1FE;
        end else begin
            idx_m  = idx;
            calm_m = cal_mask;
        end
        state_nx = ST_RUN;
        if (wc_nx[SLOT_LOG2-1:0] == '0) begin
            if (rev_bits(idx_m) < calm_m) state_nx = ST_SKIP;
        end else if ((wc_nx[SLOT_LOG2-1:0] == SLOT_MID) && insert_ok) begin
            state_nx = ST_EXTRA;
        end
    end

    // state register with the window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            wc_q    <= '1;
        end else begin
            state_q <= state_nx;
            wc_q    <= wc_nx;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_RUN:   credit = 2'd1;
            ST_SKIP:  credit = 2'd0;
            ST_EXTRA: credit = 2'd2;
            default:  credit = 2'd1;
        endcase
    end

    AST_SKIP_AT_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> (wc_q[SLOT_LOG2-1:0] == '0)); // R4

    AST_EXTRA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXTRA) |-> (cal_plus && async_reload >= ASYNC_W'(3))); // R8

    AST_EXTRA_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXTRA) |-> (wc_q[SLOT_LOG2-1:0] == SLOT_MID)); // R7

    AST_WINDOW_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wc_q == $past(wc_q) + 1'b1)); // R4

endmodule

// File: rtl/rtcpre_async_stage.sv
module rtcpre_async_stage #(
    parameter int ASYNC_W   = 7,
    parameter int DEF_ASYNC = 127
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         credit,
    input  logic [ASYNC_W-1:0] reload,
    output logic               apre_en,
    output logic               apre_q
);
    logic [ASYNC_W-1:0] acnt_q, acnt_nx;

    always_comb begin
        apre_en = 1'b0;
        acnt_nx = acnt_q;
        unique case (credit)
            2'd1: begin
                if (acnt_q == '0) begin
                    apre_en = 1'b1;
                    acnt_nx = reload;
                end else begin
                    acnt_nx = acnt_q - ASYNC_W'(1);
                end
            end
            2'd2: begin
                if (acnt_q == '0) begin
                    apre_en = 1'b1;
                    acnt_nx = reload - ASYNC_W'(1);
                end else if (acnt_q == ASYNC_W'(1)) begin
                    apre_en = 1'b1;
                    acnt_nx = reload;
                end else begin
                    acnt_nx = acnt_q - ASYNC_W'(2);
                end
            end
            default: acnt_nx = acnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt_q <= ASYNC_W'(DEF_ASYNC);
            apre_q <= 1'b0;
        end else begin
            acnt_q <= acnt_nx;
            apre_q <= apre_en;
        end
    end

    AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (credit == 2'd0) |=> $stable(acnt_q)); // R2

    AST_NO_PULSE_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (credit == 2'd0) |=> !apre_q); // R4

endmodule

// File: rtl/rtcpre_sync_stage.sv
module rtcpre_sync_stage #(
    parameter int SYNC_W   = 15,
    parameter int DEF_SYNC = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SYNC_W-1:0] reload,
    output logic [SYNC_W-1:0] subsec,
    output logic              tick_q
);
    logic [SYNC_W-1:0] scnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= SYNC_W'(DEF_SYNC);
            tick_q <= 1'b0;
        end else begin
            tick_q <= en && (scnt_q == '0);
            if (en) scnt_q <= (scnt_q == '0) ? reload : scnt_q - SYNC_W'(1);
        end
    end

    assign subsec = scnt_q;

    AST_RELOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> (scnt_q == reload)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(scnt_q)); // R3

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtcpre_pkg::*;
#(
    parameter int WIN_LOG2  = 20,
    parameter int ASYNC_W   = 7,
    parameter int SYNC_W    = 15,
    parameter int DEF_ASYNC = 127,
    parameter int DEF_SYNC  = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ASYNC_W-1:0] async_reload,
    input  logic [SYNC_W-1:0]  sync_reload,
    input  logic               cal_plus,
    input  logic [8:0]         cal_mask,
    input  logic [1:0]         cal_win,
    output logic               apre_tick,
    output logic               tick_1hz,
    output logic [SYNC_W-1:0]  subsec
);
    logic [1:0] credit;
    logic       apre_en;

    rtcpre_cal_seq #(.WIN_LOG2(WIN_LOG2), .ASYNC_W(ASYNC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cal_plus(cal_plus), .cal_mask(cal_mask),
        .cal_win(cal_win), .async_reload(async_reload), .credit(credit)
    );

    rtcpre_async_stage #(.ASYNC_W(ASYNC_W), .DEF_ASYNC(DEF_ASYNC)) u_async (
        .clk(clk), .rst_n(rst_n), .credit(credit), .reload(async_reload),
        .apre_en(apre_en), .apre_q(apre_tick)
    );

    rtcpre_sync_stage #(.SYNC_W(SYNC_W), .DEF_SYNC(DEF_SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .en(apre_en), .reload(sync_reload),
        .subsec(subsec), .tick_q(tick_1hz)
    );

    AST_TICK_WITH_APRE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> apre_tick); // R9

endmodule

// File: tb/sim_rtc_prescaler.sv
module sim_rtc_prescaler;
    localparam int WL   = 11;
    localparam int SPAN = 1 << WL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  async_reload = 7'd127;
    logic [14:0] sync_reload = 15'd255;
    logic        cal_plus = 1'b0;
    logic [8:0]  cal_mask = 9'd0;
    logic [1:0]  cal_win = 2'd0;
    logic        apre_tick, tick_1hz;
    logic [14:0] subsec;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int lone_ticks = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_prescaler #(.WIN_LOG2(WL)) u0 (
        .clk(clk), .rst_n(rst_n), .async_reload(async_reload), .sync_reload(sync_reload),
        .cal_plus(cal_plus), .cal_mask(cal_mask), .cal_win(cal_win),
        .apre_tick(apre_tick), .tick_1hz(tick_1hz), .subsec(subsec)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // counted cycles over one full span after reset (first edge is a plain count)
    function automatic int span_credits(int a, int cp, int cm, int wn);
        int masked, ins;
        if (wn >= 2)      masked = 4 * (cm >> 2);
        else if (wn == 1) masked = 2 * (cm >> 1);
        else              masked = cm;
        ins = (cp != 0 && a >= 3) ? 512 : 0;
        return 1 + SPAN + ins - masked;
    endfunction

    function automatic int exp_apre(int c, int a);
        return (c >= 128) ? 1 + (c - 128) / (a + 1) : 0;
    endfunction

    function automatic int exp_ticks(int p, int s);
        return (p >= 256) ? 1 + (p - 256) / (s + 1) : 0;
    endfunction

    function automatic int exp_sub(int p, int s);
        return (p <= 255) ? 255 - p : s - ((p - 256) % (s + 1));
    endfunction

    task automatic run_seg(input string req, input int a, input int s, input int cp,
                           input int cm, input int wn, input int ncyc, input int credits);
        int np, nt, p;
        @(negedge clk);
        rst_n        = 1'b0;
        async_reload = 7'(a);
        sync_reload  = 15'(s);
        cal_plus     = cp[0];
        cal_mask     = 9'(cm);
        cal_win      = 2'(wn);
        repeat (2) @(negedge clk);
        check("R1", "reset subsec", int'(subsec), 255);
        check("R1", "reset pulses", int'(apre_tick) + int'(tick_1hz), 0);
        rst_n = 1'b1;
        np = 0;
        nt = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            np += int'(apre_tick);
            nt += int'(tick_1hz);
            if (tick_1hz && !apre_tick) lone_ticks++;
        end
        p = exp_apre(credits, a);
        check(req, "first-stage pulses", np, p);
        check(req, "seconds ticks", nt, exp_ticks(p, s));
        check(req, "final subsec", int'(subsec), exp_sub(p, s));
    endtask

    initial begin
        wait (cyc >= 150000);
        fails++;
        checks++;
        $display("FAIL R9 watchdog: cycles %0d expected below 150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 R2: reset reload values, no calibration
        run_seg("R2", 127, 255, 0, 0, 0, SPAN + 1, span_credits(127, 0, 0, 0));
        // R3 R4: fast divide, full window masking
        run_seg("R4", 3, 7, 0, 100, 0, SPAN + 1, span_credits(3, 0, 100, 0));
        // R5: half span with cal_mask 256 loses 128 cycles (even slots only)
        run_seg("R5", 3, 7, 0, 256, 0, SPAN / 2 + 1, SPAN / 2 + 1 - 128);
        // R7: insertion at the async_reload = 3 boundary
        run_seg("R7", 3, 5, 1, 0, 0, SPAN + 1, span_credits(3, 1, 0, 0));
        run_seg("R7", 4, 3, 1, 37, 0, SPAN + 1, span_credits(4, 1, 37, 0));
        // R6: half and quarter windows, low mask bits ignored
        run_seg("R6", 3, 7, 0, 101, 1, SPAN + 1, span_credits(3, 0, 101, 1));
        run_seg("R6", 3, 7, 0, 103, 2, SPAN + 1, span_credits(3, 0, 103, 2));
        run_seg("R6", 5, 2, 0, 511, 3, SPAN + 1, span_credits(5, 0, 511, 3));
        // R8: insertion suppressed below 3
        run_seg("R8", 2, 7, 1, 10, 0, SPAN + 1, span_credits(2, 1, 10, 0));
        run_seg("R8", 0, 31, 1, 0, 0, SPAN + 1, span_credits(0, 1, 0, 0));
        // R2 R3 R4 R6 R7: random configurations
        for (int k = 0; k < 8; k++) begin
            int a, s, cp, cm, wn;
            a  = int'($urandom_range(0, 40));
            s  = int'($urandom_range(0, 31));
            cp = int'($urandom_range(0, 1));
            cm = int'($urandom_range(0, 511));
            wn = int'($urandom_range(0, 3));
            run_seg("R3", a, s, cp, cm, wn, SPAN + 1, span_credits(a, cp, cm, wn));
        end
        check("R9", "seconds tick without first-stage pulse", lone_ticks, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule